// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block follows a UART receiver that runs with nine data bits per character, the ninth bit flagging an address character on a shared multidrop line. Each address character is tested against two programmable 8-bit registers: an own-address register and an enable-mask register. Two patterns come from this one pair of registers.

The own-address pattern ignores every bit position where the mask holds 0. The broadcast pattern takes the bitwise OR of the two registers, and every 1 in that OR must also be 1 in the received address. An address that fits either pattern opens a forwarding gate, and the data characters that follow then pass to the receive FIFO interface. An address that fits neither pattern closes the gate.

A small two-state machine holds the gate. It has two states: `GATE_SHUT`, which is the reset state, and `GATE_OPEN`. There are two transitions. *accept* goes from `GATE_SHUT` to `GATE_OPEN` on a matching address character. *reject* goes from `GATE_OPEN` to `GATE_SHUT` on a non-matching address character. In every other case the state holds. A configuration bit chooses whether a matched address character is itself passed on.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, both address registers and the control register read 00h, the gate is shut, and `out_valid` and `addr_hit` are 0.
- R2: A write with `cfg_we`=1 updates the register picked by `cfg_sel` (0 = own address, 1 = enable mask, 2 = control, where bit 0 is the address-forward enable). `cfg_rdata` returns the register picked by `cfg_sel` (the control register reads back as 7'b0 followed by the enable bit), and `cfg_sel`=3 reads 00h.
- R3: An address character matches the own address when, for every bit where the mask is 1, the received bit equals the own-address bit.
- R4: An address character matches the broadcast pattern when every bit that is 1 in (own address OR mask) is also 1 in the received address.
- R5: When an address character (`rx_char[8]`=1, `rx_valid`=1) matches either pattern, `addr_hit` is 1 for exactly the next cycle. With both registers at 00h, every address matches.
- R6: A matching address character moves the gate to open and a non-matching one moves it to shut, visible on `gate_open` the next cycle. Data characters do not change the gate.
- R7: A data character (`rx_char[8]`=0) is presented the next cycle on `out_valid`/`out_data` (`rx_char[7:0]`) only if the gate was open when it arrived.
- R8: A matching address character is forwarded on `out_valid`/`out_data` only when the address-forward enable is 1. A non-matching address character is never forwarded.
- R9: A cycle with `rx_valid`=0 gives `out_valid`=0 and `addr_hit`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 9 | Received character; bit 8 marks an address |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_sel` |
| out_valid | output | 1 | Forwarded character strobe |
| out_data | output | 8 | Forwarded character |
| addr_hit | output | 1 | Address matched on the previous cycle |
| gate_open | output | 1 | Forwarding gate state |

## Verification
The assertions check on every cycle that idle cycles produce no output, that data characters leave the gate unchanged, that a hit always leaves the gate open, and that a rejected address is neither forwarded nor leaves the gate open. Only the bench's sweeps can show the match rules themselves. The bench runs all 256 address values under several register pairs, including the all-zero pair and the worked example pair, and compares the results with patterns it computes itself. The sweeps also cover register readback and the effect of the forward-enable bit.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_st_t;

    localparam logic [1:0] SEL_OWN  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/mdrop_regs.sv
module mdrop_regs
    import mdrop_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic [AW-1:0] own_addr,
    output logic [AW-1:0] en_mask,
    output logic          fwd_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr <= '0;
            en_mask  <= '0;
            fwd_addr <= 1'b0;
        end else if (we) begin
            if (sel == SEL_OWN)  own_addr <= wdata;
            if (sel == SEL_MASK) en_mask  <= wdata;
            if (sel == SEL_CTRL) fwd_addr <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_OWN:  rdata = own_addr;
            SEL_MASK: rdata = en_mask;
            SEL_CTRL: rdata = {{(AW-1){1'b0}}, fwd_addr};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdrop_match.sv
module mdrop_match #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] en_mask,
    output logic          hit_own,
    output logic          hit_bcast,
    output logic          hit_any
);
    logic [AW-1:0] bc_bits;
    logic [AW-1:0] own_ok;
    logic [AW-1:0] bc_ok;

    assign bc_bits = own_addr | en_mask;

    for (genvar b = 0; b < AW; b++) begin : g_bit
        assign own_ok[b] = !en_mask[b] || (addr_in[b] == own_addr[b]);
        assign bc_ok[b]  = !bc_bits[b] || addr_in[b];
    end

    assign hit_own   = &own_ok;
    assign hit_bcast = &bc_ok;
    assign hit_any   = hit_own | hit_bcast;
endmodule

// File: rtl/mdrop_gate_fsm.sv
module mdrop_gate_fsm
    import mdrop_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_valid,
    input  logic [AW:0]   ch,
    input  logic          hit,
    input  logic          fwd_addr,
    output logic          gate_open,
    output logic          out_valid,
    output logic [AW-1:0] out_data,
    output logic          addr_hit
);
    gate_st_t state_q, state_d;
    logic     is_addr;

    assign is_addr = ch[AW];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_SHUT: if (ch_valid && is_addr && hit)  state_d = GATE_OPEN;
            GATE_OPEN: if (ch_valid && is_addr && !hit) state_d = GATE_SHUT;
            default:   state_d = GATE_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_SHUT;
        else        state_q <= state_d;
    end

    assign gate_open = (state_q == GATE_OPEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            addr_hit  <= 1'b0;
        end else begin
            addr_hit  <= ch_valid && is_addr && hit;
            out_valid <= 1'b0;
            if (ch_valid) begin
                unique case (state_q)
                    GATE_SHUT: out_valid <= is_addr && hit && fwd_addr;
                    GATE_OPEN: out_valid <= is_addr ? (hit && fwd_addr) : 1'b1;
                    default:   out_valid <= 1'b0;
                endcase
                out_data <= ch[AW-1:0];
            end
        end
    end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [AW:0]   rx_char,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output logic          out_valid,
    output logic [AW-1:0] out_data,
    output logic          addr_hit,
    output logic          gate_open
);
    logic [AW-1:0] own_addr, en_mask;
    logic          fwd_addr;
    logic          hit_own, hit_bcast, hit_any;

    mdrop_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .own_addr(own_addr), .en_mask(en_mask), .fwd_addr(fwd_addr)
    );

    mdrop_match #(.AW(AW)) match_i (
        .addr_in(rx_char[AW-1:0]), .own_addr(own_addr), .en_mask(en_mask),
        .hit_own(hit_own), .hit_bcast(hit_bcast), .hit_any(hit_any)
    );

    mdrop_gate_fsm #(.AW(AW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .ch_valid(rx_valid), .ch(rx_char),
        .hit(hit_any), .fwd_addr(fwd_addr), .gate_open(gate_open),
        .out_valid(out_valid), .out_data(out_data), .addr_hit(addr_hit)
    );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
    parameter int AW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic [AW:0] rx_char,
    input logic        out_valid,
    input logic        addr_hit,
    input logic        gate_open,
    input logic        hit_any
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!out_valid && !addr_hit));

    // R6
    data_keeps_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_char[AW]) |=> $stable(gate_open));

    // R5
    hit_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> gate_open);

    // R8
    reject_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_char[AW] && !hit_any) |=> (!out_valid && !gate_open && !addr_hit));

    // R7
    shut_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_char[AW] && !gate_open) |=> !out_valid);
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .out_valid(out_valid), .addr_hit(addr_hit), .gate_open(gate_open),
    .hit_any(hit_any)
);

// File: tb/mdrop_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mdrop_addr_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [8:0] rx_char = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       out_valid;
    logic [7:0] out_data;
    logic       addr_hit;
    logic       gate_open;

    int total = 0;
    int bad = 0;
    logic exp_gate = 1'b0;

    always #4 clk = ~clk;

    mdrop_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_data(out_data),
        .addr_hit(addr_hit), .gate_open(gate_open)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic want_hit(input logic [7:0] a, input logic [7:0] own, input logic [7:0] msk);
        logic own_m, bc_m;
        own_m = ((a ^ own) & msk) == 8'h00;
        bc_m  = (a & (own | msk)) == (own | msk);
        return own_m || bc_m;
    endfunction

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2 readback", {24'h0, cfg_rdata}, (s == 2'd2) ? {31'h0, d[0]} : {24'h0, d});
    endtask

    task automatic send(input logic [8:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic sweep(input logic [7:0] own, input logic [7:0] msk, input logic fwd);
        wr(2'd0, own);
        wr(2'd1, msk);
        wr(2'd2, {7'h0, fwd});
        for (int a = 0; a < 256; a++) begin
            logic h;
            logic [7:0] d;
            h = want_hit(a[7:0], own, msk);
            d = a[7:0] ^ 8'h3C;
            send({1'b1, a[7:0]});
            exp_gate = h;
            check("R3/R4/R5 addr_hit", {31'h0, addr_hit}, {31'h0, h});
            check("R6 gate after address", {31'h0, gate_open}, {31'h0, exp_gate});
            check("R8 address forward", {31'h0, out_valid}, {31'h0, h & fwd});
            if (h && fwd) check("R8 address data", {24'h0, out_data}, {24'h0, a[7:0]});
            send({1'b0, d});
            check("R7 data forward", {31'h0, out_valid}, {31'h0, exp_gate});
            if (exp_gate) check("R7 data value", {24'h0, out_data}, {24'h0, d});
            check("R6 data keeps gate", {31'h0, gate_open}, {31'h0, exp_gate});
            @(negedge clk);
            check("R9 idle", {30'h0, out_valid, addr_hit}, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 gate", {31'h0, gate_open}, 32'h0);
        check("R1 outputs", {30'h0, out_valid, addr_hit}, 32'h0);
        for (int s = 0; s < 4; s++) begin
            cfg_sel = s[1:0];
            #1;
            check("R1 register reset", {24'h0, cfg_rdata}, 32'h0);
        end
        // R7 data with gate shut after reset
        send(9'h0A5);
        check("R7 shut blocks data", {31'h0, out_valid}, 32'h0);
        // R2 unused select reads zero
        cfg_sel = 2'd3;
        #1;
        check("R2 sel3 zero", {24'h0, cfg_rdata}, 32'h0);
        // R5 all-zero registers: every address matches
        sweep(8'h00, 8'h00, 1'b0);
        // R3/R4 worked example pair
        sweep(8'h5C, 8'hF9, 1'b0);
        sweep(8'h5C, 8'hF9, 1'b1);
        sweep(8'hA5, 8'hFF, 1'b0);
        sweep(8'h00, 8'hFF, 1'b1);
        sweep(8'h3C, 8'h0F, 1'b0);
        sweep(8'h81, 8'h00, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule